// File: doc/BRIEF.md
# Configuration-Mode Unlock Key Sequencer

This block guards a small indexed configuration register space reached through two I/O ports: an index port at a strapped base address and a data port one address above it. After reset the space is locked. Byte writes to the index port go to a key matcher, and only a four-byte key written in order opens configuration mode. The final key byte depends on which of the two base addresses the block is strapped to.

Once open, a write to the index port selects a register and the data port reads or writes it. The register space holds a read-only 16-bit chip identifier, a logical-device select register, and a 16-bit serial-flash controller base address. The flash base is reachable only while device 7 is selected, and it is driven out to the neighbouring flash controller. Writing the exit value to the exit register locks the space again.

Top module: `cfg_unlock_gate`

## Requirements
- R1: After reset the block is locked (`cfg_open` = 0) and `flash_base` equals 0x0820.
- R2: With `strap_alt` = 0 the index port is 0x2E and the data port is 0x2F. The byte writes 0x87, 0x01, 0x55, 0x55 to the index port open configuration mode, and `cfg_open` reads 1 from the clock edge that takes the fourth byte.
- R3: With `strap_alt` = 1 the index port is 0x4E and the data port is 0x4F. The fourth key byte is 0xAA, so 0x87, 0x01, 0x55, 0x55 leaves the block locked.
- R4: A byte that breaks the key partway returns the matcher to its start. If that byte is 0x87, it counts at once as the first key byte.
- R5: While locked, a read of the data port returns 0xFF. Data-port writes are ignored, and key bytes written to any address other than the index port do not advance the matcher.
- R6: While open, register 0x20 reads the chip identifier high byte (0x87) and register 0x21 reads the low byte (0x16). Writes to them have no effect.
- R7: Register 0x07 is a read/write logical-device select register, and it resets to 0x00.
- R8: When the device select is 0x07, register 0x64 (high byte) and register 0x65 (low byte) read and write `flash_base` in either order. With any other device selected, both read 0x00 and writes to them are ignored.
- R9: Writing 0x02 to register 0x02 locks the block from the next edge. Any other value written there leaves it open. After the exit, data reads return 0xFF and the full key is needed again.
- R10: A read of the index port returns the selected register index while open and 0xFF while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_alt | input | 1 | Base strap: 0 selects base 0x2E, 1 selects base 0x4E |
| io_wr | input | 1 | I/O write strobe, one cycle per byte |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, combinational during a read of either port, otherwise 0 |
| cfg_open | output | 1 | Configuration mode is open |
| flash_base | output | 16 | Serial-flash controller I/O base |

## Verification
A matcher that skips a step, or that fails to restart on 0x87, shows up on `cfg_open` one edge after the fourth key write. A stuck lock flag shows up at once, because data reads return 0xFF instead of the identifier bytes. A device-select gate or byte-lane error on the flash base is visible on `flash_base` the cycle after the data write, and again when that byte is read back. An exit decode that fires on the wrong value leaves the block locked, and the next data read returns 0xFF instead of register contents.

// File: rtl/cfgu_pkg.sv
package cfgu_pkg;
   localparam logic [7:0] KEY_B0      = 8'h87;
   localparam logic [7:0] KEY_B1      = 8'h01;
   localparam logic [7:0] KEY_B2      = 8'h55;
   localparam logic [7:0] KEY_LAST_P  = 8'h55;
   localparam logic [7:0] KEY_LAST_A  = 8'hAA;
   localparam int         KEY_LEN     = 4;

   localparam logic [7:0] REG_EXIT    = 8'h02;
   localparam logic [7:0] EXIT_VAL    = 8'h02;
   localparam logic [7:0] REG_DEVSEL  = 8'h07;
   localparam logic [7:0] REG_ID_HI   = 8'h20;
   localparam logic [7:0] REG_ID_LO   = 8'h21;
   localparam logic [7:0] REG_FB_HI   = 8'h64;
   localparam logic [7:0] REG_FB_LO   = 8'h65;
   localparam logic [7:0] LOCKED_RD   = 8'hFF;

   // expected key byte at a given matcher stage
   function automatic logic [7:0] key_byte(input logic [1:0] stage, input logic alt);
      case (stage)
         2'd0:    key_byte = KEY_B0;
         2'd1:    key_byte = KEY_B1;
         2'd2:    key_byte = KEY_B2;
         default: key_byte = alt ? KEY_LAST_A : KEY_LAST_P;
      endcase
   endfunction
endpackage

// File: rtl/cfgu_key_match.sv
module cfgu_key_match
   import cfgu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alt_i,
   input  logic              step_i,
   input  logic [DATA_W-1:0] byte_i,
   output logic              unlock_o
);
   localparam int ST_W = $clog2(KEY_LEN);
   localparam logic [ST_W-1:0] ST_LAST = ST_W'(KEY_LEN - 1);

   logic [ST_W-1:0]    stage_q;
   logic [KEY_LEN-1:0] hit;

   for (genvar g = 0; g < KEY_LEN; g++) begin : g_cmp
      assign hit[g] = (byte_i == key_byte(2'(g), alt_i));
   end

   assign unlock_o = step_i && hit[stage_q] && (stage_q == ST_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else if (step_i) begin
         if (hit[stage_q])
            stage_q <= (stage_q == ST_LAST) ? '0 : stage_q + 1'b1;
         else if (byte_i == KEY_B0)
            stage_q <= ST_W'(1);   // wrong byte that is itself a key start
         else
            stage_q <= '0;
      end
   end
endmodule

// File: rtl/cfgu_regs.sv
module cfgu_regs
   import cfgu_pkg::*;
#(
   parameter int                DATA_W    = 8,
   parameter logic [2*DATA_W-1:0] CHIP_ID = 16'h8716,
   parameter logic [DATA_W-1:0] FLASH_LDN = 8'h07,
   parameter logic [2*DATA_W-1:0] FLASH_RST = 16'h0820
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  open_i,
   input  logic                  idx_wr_i,
   input  logic                  dat_wr_i,
   input  logic [DATA_W-1:0]     wdata_i,
   output logic [DATA_W-1:0]     index_o,
   output logic [DATA_W-1:0]     rd_val_o,
   output logic                  exit_o,
   output logic [2*DATA_W-1:0]   flash_base_o
);
   localparam int NLANE = 2;

   logic [DATA_W-1:0] index_q;
   logic [DATA_W-1:0] devsel_q;
   logic              dev_flash;
   logic              dat_we;

   assign dat_we    = open_i && dat_wr_i;
   assign dev_flash = (devsel_q == FLASH_LDN);
   assign exit_o    = dat_we && (index_q == REG_EXIT) && (wdata_i == EXIT_VAL);
   assign index_o   = index_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               index_q <= '0;
      else if (!open_i)         index_q <= '0;
      else if (idx_wr_i)        index_q <= wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   devsel_q <= '0;
      else if (dat_we && index_q == REG_DEVSEL)     devsel_q <= wdata_i;
   end

   // one byte lane per half of the flash base; lane 0 is the low byte
   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      localparam logic [DATA_W-1:0] LANE_IDX = (g == 0) ? REG_FB_LO : REG_FB_HI;
      logic [DATA_W-1:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lane_q <= FLASH_RST[g*DATA_W +: DATA_W];
         else if (dat_we && dev_flash && index_q == LANE_IDX)
            lane_q <= wdata_i;
      end
      assign flash_base_o[g*DATA_W +: DATA_W] = lane_q;
   end

   always_comb begin
      rd_val_o = '0;
      case (index_q)
         REG_ID_HI:  rd_val_o = CHIP_ID[2*DATA_W-1:DATA_W];
         REG_ID_LO:  rd_val_o = CHIP_ID[DATA_W-1:0];
         REG_DEVSEL: rd_val_o = devsel_q;
         REG_FB_HI:  if (dev_flash) rd_val_o = flash_base_o[2*DATA_W-1:DATA_W];
         REG_FB_LO:  if (dev_flash) rd_val_o = flash_base_o[DATA_W-1:0];
         default:    rd_val_o = '0;
      endcase
   end
endmodule

// File: rtl/cfg_unlock_gate.sv
module cfg_unlock_gate
   import cfgu_pkg::*;
#(
   parameter int                  ADDR_W    = 16,
   parameter int                  DATA_W    = 8,
   parameter logic [ADDR_W-1:0]   BASE_PRI  = 'h2E,
   parameter logic [ADDR_W-1:0]   BASE_ALT  = 'h4E,
   parameter logic [2*DATA_W-1:0] CHIP_ID   = 16'h8716,
   parameter logic [DATA_W-1:0]   FLASH_LDN = 8'h07,
   parameter logic [2*DATA_W-1:0] FLASH_RST = 16'h0820
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                strap_alt,
   input  logic                io_wr,
   input  logic                io_rd,
   input  logic [ADDR_W-1:0]   io_addr,
   input  logic [DATA_W-1:0]   io_wdata,
   output logic [DATA_W-1:0]   io_rdata,
   output logic                cfg_open,
   output logic [2*DATA_W-1:0] flash_base
);
   localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

   initial begin
      assert (DATA_W == 8) else $error("DATA_W must be 8");
      assert (ADDR_W >= 8) else $error("ADDR_W too small");
      assert (BASE_PRI != BASE_ALT) else $error("base choices must differ");
   end

   logic [ADDR_W-1:0] idx_addr, dat_addr;
   logic              idx_hit, dat_hit;
   logic              open_q, unlock, exit_req;
   logic [DATA_W-1:0] index_cur, rd_val;

   assign idx_addr = strap_alt ? BASE_ALT : BASE_PRI;
   assign dat_addr = idx_addr + ONE;
   assign idx_hit  = (io_addr == idx_addr);
   assign dat_hit  = (io_addr == dat_addr);

   cfgu_key_match #(.DATA_W(DATA_W)) u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .alt_i    (strap_alt),
      .step_i   (io_wr && idx_hit && !open_q),
      .byte_i   (io_wdata),
      .unlock_o (unlock)
   );

   cfgu_regs #(
      .DATA_W(DATA_W), .CHIP_ID(CHIP_ID), .FLASH_LDN(FLASH_LDN), .FLASH_RST(FLASH_RST)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .open_i       (open_q),
      .idx_wr_i     (io_wr && idx_hit),
      .dat_wr_i     (io_wr && dat_hit),
      .wdata_i      (io_wdata),
      .index_o      (index_cur),
      .rd_val_o     (rd_val),
      .exit_o       (exit_req),
      .flash_base_o (flash_base)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        open_q <= 1'b0;
      else if (unlock)   open_q <= 1'b1;
      else if (exit_req) open_q <= 1'b0;
   end

   assign cfg_open = open_q;

   always_comb begin
      io_rdata = '0;
      if (io_rd && idx_hit)      io_rdata = open_q ? index_cur : LOCKED_RD;
      else if (io_rd && dat_hit) io_rdata = open_q ? rd_val : LOCKED_RD;
   end
endmodule

// File: rtl/cfgu_checker.sv
module cfgu_checker #(
   parameter int                  ADDR_W   = 16,
   parameter int                  DATA_W   = 8,
   parameter logic [ADDR_W-1:0]   BASE_PRI = 'h2E,
   parameter logic [ADDR_W-1:0]   BASE_ALT = 'h4E,
   parameter logic [2*DATA_W-1:0] CHIP_ID  = 16'h8716
) (
   input logic                clk,
   input logic                rst_n,
   input logic                strap_alt,
   input logic                io_wr,
   input logic                io_rd,
   input logic [ADDR_W-1:0]   io_addr,
   input logic [DATA_W-1:0]   io_wdata,
   input logic [DATA_W-1:0]   io_rdata,
   input logic                cfg_open,
   input logic [2*DATA_W-1:0] flash_base,
   input logic [DATA_W-1:0]   cur_index
);
   logic [ADDR_W-1:0] ia, da;
   assign ia = strap_alt ? BASE_ALT : BASE_PRI;
   assign da = ia + {{(ADDR_W-1){1'b0}}, 1'b1};

   // R2: the lock opens only on an edge that took an index-port write
   a_r2_open_from_index: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_open) |-> $past(io_wr && io_addr == ia));

   // R5: data reads are blanked while locked
   a_r5_locked_data_ff: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_open && io_rd && io_addr == da) |-> io_rdata == 8'hFF);

   // R6: identifier high byte
   a_r6_id_high: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_open && io_rd && io_addr == da && cur_index == 8'h20) |-> io_rdata == CHIP_ID[2*DATA_W-1:DATA_W]);

   // R8: the flash base cannot move while locked
   a_r8_base_held_locked: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_open |=> $stable(flash_base));

   // R9: exit command locks on the next edge
   a_r9_exit_locks: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_open && io_wr && io_addr == da && cur_index == 8'h02 && io_wdata == 8'h02) |=> !cfg_open);

   // R10: index reads are blanked while locked
   a_r10_locked_index_ff: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_open && io_rd && io_addr == ia) |-> io_rdata == 8'hFF);
endmodule

bind cfg_unlock_gate cfgu_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_PRI(BASE_PRI), .BASE_ALT(BASE_ALT), .CHIP_ID(CHIP_ID)
) u_chk (
   .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .io_wr(io_wr), .io_rd(io_rd),
   .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_open(cfg_open),
   .flash_base(flash_base), .cur_index(u_regs.index_o)
);

// File: tb/cfg_unlock_gate_bench.sv
module cfg_unlock_gate_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strap_alt = 1'b0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [15:0] io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic        cfg_open;
   logic [15:0] flash_base;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   cfg_unlock_gate u_cfg_unlock_gate (
      .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .io_wr(io_wr), .io_rd(io_rd),
      .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .cfg_open(cfg_open), .flash_base(flash_base)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic alt);
      @(negedge clk);
      rst_n = 1'b0; strap_alt = alt;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_wr = 1'b1; io_addr = a; io_wdata = d;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      io_rd = 1'b1; io_addr = a;
      #1 d = io_rdata;
      @(negedge clk);
      io_rd = 1'b0;
   endtask

   task automatic key4(input logic [15:0] a, input logic [7:0] last);
      wr(a, 8'h87); wr(a, 8'h01); wr(a, 8'h55); wr(a, last);
   endtask

   task automatic reg_wr(input logic [15:0] b, input logic [7:0] r, input logic [7:0] d);
      wr(b, r); wr(b + 16'd1, d);
   endtask

   task automatic reg_rd(input logic [15:0] b, input logic [7:0] r, output logic [7:0] d);
      wr(b, r); rd(b + 16'd1, d);
   endtask

   task automatic t_reset_state();
      logic [7:0] d;
      do_reset(1'b0);
      check("R1 locked after reset", 16'(cfg_open), 16'h0);
      check("R1 flash base reset", flash_base, 16'h0820);
      rd(16'h002F, d); check("R5 locked data read", 16'(d), 16'h00FF);
      rd(16'h002E, d); check("R10 locked index read", 16'(d), 16'h00FF);
   endtask

   task automatic t_locked_ignores();
      wr(16'h002F, 8'h33);
      key4(16'h002F, 8'h55);
      check("R5 key on data port ignored", 16'(cfg_open), 16'h0);
      key4(16'h004E, 8'h55);
      check("R5 key on other base ignored", 16'(cfg_open), 16'h0);
   endtask

   task automatic t_unlock_primary();
      logic [7:0] d;
      key4(16'h002E, 8'h55);
      check("R2 open after key", 16'(cfg_open), 16'h1);
      reg_rd(16'h002E, 8'h20, d); check("R6 id high", 16'(d), 16'h0087);
      reg_rd(16'h002E, 8'h21, d); check("R6 id low", 16'(d), 16'h0016);
      reg_wr(16'h002E, 8'h20, 8'h00);
      reg_rd(16'h002E, 8'h20, d); check("R6 id read-only", 16'(d), 16'h0087);
      rd(16'h002E, d); check("R10 index readback", 16'(d), 16'h0020);
   endtask

   task automatic t_flash_base();
      logic [7:0] d;
      reg_rd(16'h002E, 8'h07, d); check("R7 devsel reset", 16'(d), 16'h0000);
      reg_wr(16'h002E, 8'h07, 8'h03);
      reg_rd(16'h002E, 8'h07, d); check("R7 devsel readback", 16'(d), 16'h0003);
      reg_rd(16'h002E, 8'h64, d); check("R8 hidden when device 3", 16'(d), 16'h0000);
      reg_wr(16'h002E, 8'h64, 8'h12);
      check("R8 write ignored when device 3", flash_base, 16'h0820);
      reg_wr(16'h002E, 8'h07, 8'h07);
      reg_wr(16'h002E, 8'h65, 8'h34);
      check("R8 low byte first", flash_base, 16'h0834);
      reg_wr(16'h002E, 8'h64, 8'h12);
      check("R8 then high byte", flash_base, 16'h1234);
      reg_rd(16'h002E, 8'h64, d); check("R8 read high", 16'(d), 16'h0012);
      reg_rd(16'h002E, 8'h65, d); check("R8 read low", 16'(d), 16'h0034);
      reg_wr(16'h002E, 8'h64, 8'hAB);
      reg_wr(16'h002E, 8'h65, 8'hCD);
      check("R8 high byte first", flash_base, 16'hABCD);
   endtask

   task automatic t_exit();
      logic [7:0] d;
      reg_wr(16'h002E, 8'h02, 8'h01);
      check("R9 other value keeps open", 16'(cfg_open), 16'h1);
      reg_wr(16'h002E, 8'h02, 8'h02);
      check("R9 exit locks", 16'(cfg_open), 16'h0);
      rd(16'h002F, d); check("R9 data blank after exit", 16'(d), 16'h00FF);
      wr(16'h002E, 8'h55);
      check("R9 single byte does not reopen", 16'(cfg_open), 16'h0);
      check("R5 base kept while locked", flash_base, 16'hABCD);
   endtask

   task automatic t_wrong_bytes();
      wr(16'h002E, 8'h87); wr(16'h002E, 8'h01); wr(16'h002E, 8'h00);
      wr(16'h002E, 8'h55); wr(16'h002E, 8'h55);
      check("R4 broken key stays locked", 16'(cfg_open), 16'h0);
      wr(16'h002E, 8'h87); key4(16'h002E, 8'h55);
      check("R4 restart on 87 at stage 1", 16'(cfg_open), 16'h1);
      reg_wr(16'h002E, 8'h02, 8'h02);
      wr(16'h002E, 8'h87); wr(16'h002E, 8'h01); wr(16'h002E, 8'h55);
      wr(16'h002E, 8'h87); wr(16'h002E, 8'h01); wr(16'h002E, 8'h55); wr(16'h002E, 8'h55);
      check("R4 restart on 87 at last stage", 16'(cfg_open), 16'h1);
      reg_wr(16'h002E, 8'h02, 8'h02);
   endtask

   task automatic t_alt_base();
      logic [7:0] d;
      do_reset(1'b1);
      check("R1 base restored by reset", flash_base, 16'h0820);
      key4(16'h004E, 8'h55);
      check("R3 primary last byte rejected", 16'(cfg_open), 16'h0);
      key4(16'h002E, 8'hAA);
      check("R3 old base ignored", 16'(cfg_open), 16'h0);
      key4(16'h004E, 8'hAA);
      check("R3 alt key opens", 16'(cfg_open), 16'h1);
      reg_rd(16'h004E, 8'h21, d); check("R3 alt data port", 16'(d), 16'h0016);
   endtask

   initial begin
      t_reset_state();
      t_locked_ignores();
      t_unlock_primary();
      t_flash_base();
      t_exit();
      t_wrong_bytes();
      t_alt_base();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule